// File: doc/BRIEF.md
# Exception Entry Sequencer

This block holds the processor status word and performs the state changes of an exception entry. The status word carries four condition flags, an interrupt-disable bit, a fast-interrupt-disable bit and a 5-bit mode code. Reserved positions stay at zero. Each cycle the block looks at the exception requests and at the synchronised fast-interrupt line. It drops the interrupt requests that are currently masked and grants the one left with the highest priority.

A granted entry produces a one-cycle strobe. The strobe comes with the target mode code, the link value, which is the return address to store in that mode's banked link register, and a copy of the full status word to store in that mode's saved status register. It also gives the vector address the fetch unit must jump to. In the same clock edge the status word takes the new mode and its disable bits are set.

Outside an entry, privileged software may rewrite the disable bits and the mode. Any mode may update the flags through a separate port.

Top module: `exc_entry_seq`

## Requirements
- R1: On a granted entry, `entry_strobe` is high for exactly the cycle after the request edge. In that cycle `entry_lr` equals `ret_addr` as sampled at that edge, `entry_spsr` equals the whole status word from before the edge, and `entry_mode` is the target mode code.
- R2: An entry loads the status mode field and `entry_vector` with these values:
  - data abort: mode 5'b10111, vector 0x10
  - fast interrupt: mode 5'b10001, vector 0x1C
  - interrupt: mode 5'b10010, vector 0x18
  - prefetch abort: mode 5'b10111, vector 0x0C
  - undefined: mode 5'b11011, vector 0x04
  - software interrupt: mode 5'b10011, vector 0x08
- R3: Every entry sets the interrupt-disable bit (status bit 7). A fast-interrupt entry also sets the fast-interrupt-disable bit (bit 6). All other entries leave bit 6 unchanged.
- R4: `fiq_async` passes through one register before arbitration. A level that rises before clock edge k cannot produce an entry before edge k+1.
- R5: Requests pending in the same cycle are granted in this fixed order: data abort, fast interrupt, interrupt, prefetch abort, undefined, software interrupt.
- R6: An interrupt request is ignored while status bit 7 is set. A fast-interrupt request is ignored while bit 6 is set. A request held high is granted once its disable bit clears.
- R7: In a privileged mode, a control write updates bits 7, 6 and 4:0 from `ctl_wr_data`. If `ctl_wr_data[4:0]` is not one of the six mode codes, the whole write is ignored.
- R8: In User mode (5'b10000), a control write has no effect on the status word.
- R9: A flag write replaces status bits 31:28 with `flag_wr_data` in any mode.
- R10: Status bits 27:8 and bit 5 stay zero. No control write and no flag write changes them, and a control write never changes bits 31:28.
- R11: A synchronous reset sets the status word to 0x000000D3 (Supervisor, both disable bits set, flags clear) and holds `entry_strobe` low.
- R12: When an entry is granted in the same cycle as a control or flag write, the entry wins and both writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dabt_req | input | 1 | Data abort request |
| pabt_req | input | 1 | Prefetch abort request |
| undef_req | input | 1 | Undefined instruction request |
| swi_req | input | 1 | Software interrupt request |
| irq_req | input | 1 | Interrupt request level |
| fiq_async | input | 1 | Asynchronous fast-interrupt level |
| ret_addr | input | AW | Return address to bank on entry |
| ctl_wr_en | input | 1 | Control-bit write enable |
| ctl_wr_data | input | 32 | Control write value (bits 7, 6, 4:0 used) |
| flag_wr_en | input | 1 | Flag write enable |
| flag_wr_data | input | 4 | New condition flags |
| status_word | output | 32 | Current status word |
| entry_strobe | output | 1 | One-cycle entry pulse |
| entry_vector | output | AW | Vector address to fetch from |
| entry_mode | output | 5 | Mode whose banked registers are written |
| entry_lr | output | AW | Value for the banked link register |
| entry_spsr | output | 32 | Value for the saved status register |

## Verification
The assertions assume that every input except `fiq_async` changes only between clock edges. They also assume that a synchronous request is held high only for as long as the requester wants repeated entries, because a held abort is granted again on every cycle. The stimulus therefore drives every input on the falling edge. It pulses the abort, undefined and software-interrupt requests for a single cycle. Only the interrupt and fast-interrupt levels are held across cycles, and only to exercise masking and late grants.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011
    } mode_e;

    // Encoding order is the grant priority: lower value wins.
    localparam int NUM_EXC = 6;
    localparam int EXC_W   = $clog2(NUM_EXC);

    typedef enum logic [EXC_W-1:0] {
        EXC_DABT = 3'd0,
        EXC_FIQ  = 3'd1,
        EXC_IRQ  = 3'd2,
        EXC_PABT = 3'd3,
        EXC_UND  = 3'd4,
        EXC_SWI  = 3'd5
    } exc_e;

    typedef struct packed {
        logic [3:0]  flags;
        logic [19:0] resv_hi;
        logic        irq_off;
        logic        fiq_off;
        logic        resv_lo;
        mode_e       mode;
    } psr_t;

    typedef struct packed {
        logic valid;
        exc_e kind;
    } grant_t;

    localparam psr_t PSR_RESET = '{flags: 4'h0, resv_hi: 20'h0, irq_off: 1'b1,
                                   fiq_off: 1'b1, resv_lo: 1'b0, mode: MODE_SVC};

    function automatic mode_e exc_mode(exc_e k);
        case (k)
            EXC_DABT, EXC_PABT: return MODE_ABT;
            EXC_FIQ:            return MODE_FIQ;
            EXC_IRQ:            return MODE_IRQ;
            EXC_UND:            return MODE_UND;
            default:            return MODE_SVC;
        endcase
    endfunction

    function automatic logic [7:0] exc_vector(exc_e k);
        case (k)
            EXC_DABT: return 8'h10;
            EXC_FIQ:  return 8'h1C;
            EXC_IRQ:  return 8'h18;
            EXC_PABT: return 8'h0C;
            EXC_UND:  return 8'h04;
            default:  return 8'h08;
        endcase
    endfunction

    function automatic logic exc_masks_fiq(exc_e k);
        return k == EXC_FIQ;
    endfunction

    function automatic logic mode_is_valid(logic [4:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ,
            MODE_SVC, MODE_ABT, MODE_UND: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/esq_fiq_sync.sv
module esq_fiq_sync #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/esq_arbiter.sv
module esq_arbiter
    import exc_seq_pkg::*;
(
    input  logic [NUM_EXC-1:0] pend,
    output grant_t             grant
);
    // Scan from the lowest priority up, so the lowest index is the last one written.
    always_comb begin
        grant = '0;
        for (int i = NUM_EXC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                grant.valid = 1'b1;
                grant.kind  = exc_e'(EXC_W'(i));
            end
        end
    end

endmodule

// File: rtl/esq_status_reg.sv
module esq_status_reg
    import exc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  grant_t      grant,
    input  logic        ctl_wr_en,
    input  logic [31:0] ctl_wr_data,
    input  logic        flag_wr_en,
    input  logic [3:0]  flag_wr_data,
    output psr_t        psr_q
);
    psr_t wr_view;
    logic ctl_ok;

    assign wr_view = psr_t'(ctl_wr_data);
    assign ctl_ok  = ctl_wr_en && (psr_q.mode != MODE_USR) && mode_is_valid(ctl_wr_data[4:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            psr_q <= PSR_RESET;
        end else if (grant.valid) begin
            psr_q.mode    <= exc_mode(grant.kind);
            psr_q.irq_off <= 1'b1;
            if (exc_masks_fiq(grant.kind)) psr_q.fiq_off <= 1'b1;
        end else begin
            if (ctl_ok) begin
                psr_q.mode    <= wr_view.mode;
                psr_q.irq_off <= wr_view.irq_off;
                psr_q.fiq_off <= wr_view.fiq_off;
            end
            if (flag_wr_en) psr_q.flags <= flag_wr_data;
        end
    end

    assert_resv_kept_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable({psr_q.resv_hi, psr_q.resv_lo}));

    assert_user_ctl_noop_R8: assert property (@(posedge clk) disable iff (rst)
        (!grant.valid && !flag_wr_en && ctl_wr_en && psr_q.mode == MODE_USR) |=> $stable(psr_q));

    assert_entry_sets_i_R3: assert property (@(posedge clk) disable iff (rst)
        grant.valid |=> psr_q.irq_off);

    assert_entry_drops_write_R12: assert property (@(posedge clk) disable iff (rst)
        grant.valid |=> $stable(psr_q.flags));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int SYNC_STAGES = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dabt_req,
    input  logic          pabt_req,
    input  logic          undef_req,
    input  logic          swi_req,
    input  logic          irq_req,
    input  logic          fiq_async,
    input  logic [AW-1:0] ret_addr,
    input  logic          ctl_wr_en,
    input  logic [31:0]   ctl_wr_data,
    input  logic          flag_wr_en,
    input  logic [3:0]    flag_wr_data,
    output logic [31:0]   status_word,
    output logic          entry_strobe,
    output logic [AW-1:0] entry_vector,
    output logic [4:0]    entry_mode,
    output logic [AW-1:0] entry_lr,
    output logic [31:0]   entry_spsr
);
    logic               fiq_sync;
    psr_t               psr_q;
    logic [NUM_EXC-1:0] pend;
    grant_t             grant;

    esq_fiq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (fiq_async),
        .q   (fiq_sync)
    );

    // Bit index equals the exc_e value of each source.
    assign pend = {swi_req,
                   undef_req,
                   pabt_req,
                   irq_req  & ~psr_q.irq_off,
                   fiq_sync & ~psr_q.fiq_off,
                   dabt_req};

    esq_arbiter u_arb (
        .pend  (pend),
        .grant (grant)
    );

    esq_status_reg u_psr (
        .clk          (clk),
        .rst          (rst),
        .grant        (grant),
        .ctl_wr_en    (ctl_wr_en),
        .ctl_wr_data  (ctl_wr_data),
        .flag_wr_en   (flag_wr_en),
        .flag_wr_data (flag_wr_data),
        .psr_q        (psr_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_strobe <= 1'b0;
            entry_vector <= '0;
            entry_mode   <= MODE_SVC;
            entry_lr     <= '0;
            entry_spsr   <= '0;
        end else begin
            entry_strobe <= grant.valid;
            if (grant.valid) begin
                entry_vector <= AW'(exc_vector(grant.kind));
                entry_mode   <= exc_mode(grant.kind);
                entry_lr     <= ret_addr;
                entry_spsr   <= psr_q;
            end
        end
    end

    assign status_word = psr_q;

    assert_spsr_copy_R1: assert property (@(posedge clk) disable iff (rst)
        entry_strobe |-> (entry_spsr == $past(status_word)));

    assert_mode_follows_R2: assert property (@(posedge clk) disable iff (rst)
        entry_strobe |-> (status_word[4:0] == entry_mode));

    assert_fiq_synced_R4: assert property (@(posedge clk) disable iff (rst)
        (entry_strobe && entry_mode == MODE_FIQ) |-> $past(fiq_sync));

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (entry_strobe && entry_mode == MODE_IRQ) |-> !$past(status_word[7]));

    assert_abort_first_R5: assert property (@(posedge clk) disable iff (rst)
        (entry_strobe && entry_mode != MODE_ABT) |-> !$past(dabt_req));

endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dabt_req = 0, pabt_req = 0, undef_req = 0, swi_req = 0;
    logic          irq_req = 0, fiq_async = 0;
    logic [AW-1:0] ret_addr = '0;
    logic          ctl_wr_en = 0;
    logic [31:0]   ctl_wr_data = '0;
    logic          flag_wr_en = 0;
    logic [3:0]    flag_wr_data = '0;
    logic [31:0]   status_word;
    logic          entry_strobe;
    logic [AW-1:0] entry_vector;
    logic [4:0]    entry_mode;
    logic [AW-1:0] entry_lr;
    logic [31:0]   entry_spsr;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    exc_entry_seq #(.AW(AW)) i_exc_entry_seq (
        .clk(clk), .rst(rst),
        .dabt_req(dabt_req), .pabt_req(pabt_req), .undef_req(undef_req),
        .swi_req(swi_req), .irq_req(irq_req), .fiq_async(fiq_async),
        .ret_addr(ret_addr),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .status_word(status_word), .entry_strobe(entry_strobe),
        .entry_vector(entry_vector), .entry_mode(entry_mode),
        .entry_lr(entry_lr), .entry_spsr(entry_spsr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        dabt_req = 0; pabt_req = 0; undef_req = 0; swi_req = 0;
        irq_req = 0; fiq_async = 0; ctl_wr_en = 0; flag_wr_en = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic ctl_write(input logic [31:0] d);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        step();
        ctl_wr_en = 1'b0;
    endtask

    task automatic flag_write(input logic [3:0] d);
        flag_wr_en = 1'b1; flag_wr_data = d;
        step();
        flag_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11 status", status_word, 32'h0000_00D3);
        chk("R11 strobe", 32'(entry_strobe), 32'd0);
    endtask

    task automatic t_dabort();
        do_reset();
        ctl_write(32'h13);
        chk("R7 ctl write", status_word, 32'h13);
        ret_addr = 32'h0000_0100;
        dabt_req = 1'b1;
        step();
        dabt_req = 1'b0;
        chk("R1 strobe", 32'(entry_strobe), 32'd1);
        chk("R1 lr", entry_lr, 32'h100);
        chk("R1 spsr", entry_spsr, 32'h13);
        chk("R1 mode", 32'(entry_mode), 32'h17);
        chk("R2 vector", entry_vector, 32'h10);
        chk("R3 status", status_word, 32'h97);
        step();
        chk("R1 single pulse", 32'(entry_strobe), 32'd0);
    endtask

    task automatic t_fiq();
        do_reset();
        ctl_write(32'h13);
        fiq_async = 1'b1;
        step();
        chk("R4 no early entry", 32'(entry_strobe), 32'd0);
        step();
        chk("R4 strobe", 32'(entry_strobe), 32'd1);
        chk("R2 fiq vector", entry_vector, 32'h1C);
        chk("R2 fiq mode", 32'(entry_mode), 32'h11);
        chk("R3 fiq status", status_word, 32'hD1);
        step();
        chk("R6 fiq masked", 32'(entry_strobe), 32'd0);
        fiq_async = 1'b0;
        step();
    endtask

    task automatic t_irq();
        do_reset();
        irq_req = 1'b1;
        step();
        step();
        chk("R6 irq masked", 32'(entry_strobe), 32'd0);
        ctl_wr_en = 1'b1; ctl_wr_data = 32'h13;
        step();
        ctl_wr_en = 1'b0;
        chk("R6 no entry yet", 32'(entry_strobe), 32'd0);
        chk("R7 unmask", status_word, 32'h13);
        step();
        chk("R6 late grant", 32'(entry_strobe), 32'd1);
        chk("R2 irq vector", entry_vector, 32'h18);
        chk("R2 irq mode", 32'(entry_mode), 32'h12);
        chk("R3 irq status", status_word, 32'h92);
        chk("R1 irq spsr", entry_spsr, 32'h13);
        irq_req = 1'b0;
        step();
    endtask

    task automatic prio_case(input string tag, input logic fq, input logic da, input logic ir,
                             input logic pa, input logic un, input logic sw,
                             input logic [31:0] exp_vec);
        do_reset();
        ctl_write(32'h13);
        if (fq) begin
            fiq_async = 1'b1;
            step();
        end
        dabt_req = da; irq_req = ir; pabt_req = pa; undef_req = un; swi_req = sw;
        step();
        clear_inputs();
        chk(tag, entry_vector, exp_vec);
        chk(tag, 32'(entry_strobe), 32'd1);
    endtask

    task automatic t_priority();
        prio_case("R5 dabt first", 1, 1, 1, 1, 0, 1, 32'h10);
        prio_case("R5 fiq over irq", 1, 0, 1, 1, 0, 0, 32'h1C);
        prio_case("R5 irq over pabt", 0, 0, 1, 1, 1, 0, 32'h18);
        prio_case("R5 pabt over und", 0, 0, 0, 1, 1, 1, 32'h0C);
        prio_case("R5 und over swi", 0, 0, 0, 0, 1, 1, 32'h04);
        chk("R2 und mode", 32'(entry_mode), 32'h1B);
        prio_case("R5 swi alone", 0, 0, 0, 0, 0, 1, 32'h08);
        chk("R2 swi status", status_word, 32'h93);
    endtask

    task automatic t_user();
        do_reset();
        ctl_write(32'h10);
        chk("R7 to user", status_word, 32'h10);
        ctl_write(32'hD3);
        chk("R8 user noop", status_word, 32'h10);
        ctl_write(32'h13);
        chk("R8 user noop mode", status_word, 32'h10);
        swi_req = 1'b1;
        step();
        swi_req = 1'b0;
        chk("R1 user spsr", entry_spsr, 32'h10);
        chk("R2 from user", status_word, 32'h93);
    endtask

    task automatic t_flags();
        do_reset();
        flag_write(4'h9);
        chk("R9 flags priv", status_word, 32'h9000_00D3);
        ctl_write(32'h10);
        flag_write(4'h5);
        chk("R9 flags user", status_word, 32'h5000_0010);
    endtask

    task automatic t_reserved();
        do_reset();
        ctl_write(32'hFFFF_FF33);
        chk("R10 reserved", status_word, 32'h13);
        flag_write(4'hF);
        chk("R10 after flags", status_word, 32'hF000_0013);
    endtask

    task automatic t_invalid();
        do_reset();
        ctl_write(32'h13);
        ctl_write(32'hC5);
        chk("R7 invalid mode", status_word, 32'h13);
    endtask

    task automatic t_collide();
        do_reset();
        ctl_write(32'h13);
        swi_req = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_data = 32'h10;
        flag_wr_en = 1'b1; flag_wr_data = 4'hF;
        step();
        clear_inputs();
        chk("R12 entry wins", status_word, 32'h93);
        chk("R12 strobe", 32'(entry_strobe), 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_dabort();
        t_fiq();
        t_irq();
        t_priority();
        t_user();
        t_flags();
        t_reserved();
        t_invalid();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule